// File: doc/BRIEF.md
# EDO DRAM macro controller

This block sits between a synchronous request port and an asynchronous embedded EDO DRAM array of 512 rows by 256 columns of 32-bit words. A requester offers one word access at a time on a valid/ready handshake, giving a write flag, a 17-bit word address, write data and a per-byte enable. The controller splits the address into row and column. It presents both to the array together, since the array does not multiplex its address pins. It then sequences the row strobe, column strobe, write enable and output enable in whole clock cycles.

Each access is timed from three parameters, each given in clock cycles: read access latency, row precharge time and full row cycle time. At 100 MHz these are 3, 2 and 6. Reads return the sampled array word with a one-cycle valid pulse. Writes drive separate data-in lines and four active-low byte masks, where a LOW mask line protects its byte.

A free-running interval timer raises a refresh request every 1560 cycles, which keeps 512 rows inside an 8 ms window. The sequencer serves a pending refresh before any waiting request, using the column-before-row strobe order, which needs no address.

Top module: `edo_macro_ctl`

## Requirements
- R1: After reset, and whenever no access or refresh is in progress, the row, column, write and output strobes are all high, `rsp_valid` is low, and `req_ready` is high unless a refresh is pending.
- R2: For an accepted request, `dram_row` carries address bits 16:8 and `dram_col` carries address bits 7:0, both valid from the cycle the row strobe falls.
- R3: A write holds `dram_we_n` low and `dram_oe_n` high while the row strobe is low. It drives `req_wdata` on `dram_din` and sets `dram_mask[i]` HIGH exactly when `req_be[i]` is 1, so that byte i (bits 8i+7:8i) is written and every byte with a LOW mask line keeps its old value. A write produces no response.
- R4: A read holds `dram_oe_n` low and `dram_we_n` high. It samples `dram_dout` T_RAC (3) cycles after the accepting clock edge and presents the word with `rsp_valid` high for exactly one cycle.
- R5: In a normal access the row strobe falls on the accepting edge while the column strobe is still high, and the column strobe falls one cycle later.
- R6: The row strobe stays high for at least T_RP (2) cycles before each fall, and successive falls are at least T_RC (6) cycles apart. Two back-to-back requests are accepted exactly T_RC cycles apart.
- R7: A refresh is due every REF_INTERVAL (1560) cycles. It is performed with the column strobe falling while the row strobe is high and the write strobe high, and the row strobe falling on the next cycle.
- R8: While a refresh is pending the controller refuses new requests and starts the refresh as soon as it is idle. The column strobe of the refresh falls between 1 and T_RC+1 cycles after the due edge.
- R9: `req_ready` is low while an access or refresh is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address, row in 16:8, column in 7:0 |
| req_wdata | input | 32 | Write word |
| req_be | input | 4 | Byte enables, bit i enables bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read word |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_row | output | 9 | Row address |
| dram_col | output | 8 | Column address |
| dram_mask | output | 4 | Byte masks, LOW protects the byte |
| dram_din | output | 32 | Data toward the array |
| dram_dout | input | 32 | Data from the array |

## Verification
The assertions check on every cycle that the strobes rest high when idle and that the column strobe leads the row strobe in refresh but trails it in normal access. They also check the precharge and row-cycle minimums with counters, that byte masks open only during writes, and that read responses are single pulses following an output-enabled access. Whether the correct bytes land in the array, whether read data matches prior writes, and whether the sampling latency equals T_RAC are shown only by the bench's array model and scoreboard. The same holds for whether refresh starts promptly after each due point and whether the number of refreshes matches elapsed time.

// File: rtl/edo_pkg.sv
package edo_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACT  = 3'd1,
      ST_PRE  = 3'd2,
      ST_RCAS = 3'd3,
      ST_RRAS = 3'd4
   } edo_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
   parameter int INTERVAL = 1560
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = $clog2(INTERVAL);

   if (INTERVAL < 2) begin : g_bad_interval
      $error("edo_ref_timer: INTERVAL must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (cnt == CW'(INTERVAL - 1)) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = (cnt == CW'(INTERVAL - 1));

endmodule

// File: rtl/edo_mask_gen.sv
module edo_mask_gen #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              wr_active,
   input  logic [LANES-1:0]  be,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  mask,
   output logic [DATA_W-1:0] din
);
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("edo_mask_gen: LANES and LANE_W must be positive");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      // enabled byte raises its mask line; a LOW line protects the byte
      assign mask[i] = wr_active & be[i];
      assign din[i*LANE_W +: LANE_W] = wr_active ? wdata[i*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/edo_seq.sv
module edo_seq import edo_pkg::*; #(
   parameter int ROW_W  = 9,
   parameter int COL_W  = 8,
   parameter int DATA_W = 32,
   parameter int BE_W   = 4,
   parameter int T_RAC  = 3,
   parameter int T_RP   = 2,
   parameter int T_RC   = 6,
   localparam int ADDR_W = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   input  logic              ref_tick,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ROW_W-1:0]  row,
   output logic [COL_W-1:0]  col,
   output logic              wr_active,
   output logic [DATA_W-1:0] wdata_q,
   output logic [BE_W-1:0]   be_q,
   input  logic [DATA_W-1:0] dram_dout
);
   localparam int ACT_LEN = imax(T_RC - T_RP - 1, T_RAC);
   localparam int CNT_MAX = imax(ACT_LEN, T_RP);
   localparam int CW      = $clog2(CNT_MAX + 1);
   localparam int SW      = $clog2(T_RC + 1) + 1;

   if (T_RAC < 1 || T_RP < 1) begin : g_bad_timing
      $error("edo_seq: T_RAC and T_RP must be at least one cycle");
   end
   if (T_RC < T_RP + 2) begin : g_bad_cycle
      $error("edo_seq: T_RC too short for precharge");
   end

   edo_state_e        state;
   logic [CW-1:0]     cnt;
   logic              op_wr;
   logic [ADDR_W-1:0] addr_q;
   logic              ref_pend;

   wire act_last  = (cnt == CW'(ACT_LEN - 1));
   wire pre_last  = (cnt == CW'(T_RP - 1));
   wire rd_sample = (state == ST_ACT) && !op_wr && (cnt == CW'(T_RAC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         op_wr   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (ref_pend) begin
                  state <= ST_RCAS;
               end else if (req_valid) begin
                  state   <= ST_ACT;
                  op_wr   <= req_write;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
               end
            end
            ST_ACT: begin
               if (act_last) begin
                  state <= ST_PRE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PRE: begin
               if (pre_last) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RCAS: begin
               state <= ST_RRAS;
               cnt   <= '0;
            end
            ST_RRAS: begin
               if (act_last) begin
                  state <= ST_PRE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // refresh request: a new tick wins over completion
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_pend <= 1'b0;
      end else if (ref_tick) begin
         ref_pend <= 1'b1;
      end else if (state == ST_RRAS && act_last) begin
         ref_pend <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_sample;
         if (rd_sample) begin
            rsp_rdata <= dram_dout;
         end
      end
   end

   always_comb begin
      ras_n     = !(state == ST_ACT || state == ST_RRAS);
      cas_n     = !((state == ST_ACT && cnt != '0) || state == ST_RCAS || state == ST_RRAS);
      we_n      = !(state == ST_ACT && op_wr);
      oe_n      = !(state == ST_ACT && !op_wr);
      wr_active = (state == ST_ACT) && op_wr;
      req_ready = (state == ST_IDLE) && !ref_pend;
   end

   assign row = addr_q[ADDR_W-1:COL_W];
   assign col = addr_q[COL_W-1:0];

   // ---------------- checks ----------------
   logic          ras_q;
   logic [SW-1:0] since_fall;
   logic [SW-1:0] hi_cnt;
   wire           ras_fell = ras_q && !ras_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_q      <= 1'b1;
         since_fall <= SW'(T_RC);
         hi_cnt     <= SW'(T_RP);
      end else begin
         ras_q <= ras_n;
         if (ras_fell) begin
            since_fall <= SW'(1);
         end else if (since_fall != {SW{1'b1}}) begin
            since_fall <= since_fall + 1'b1;
         end
         if (!ras_n) begin
            hi_cnt <= '0;
         end else if (hi_cnt != {SW{1'b1}}) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (ras_n && cas_n && we_n && oe_n)); // R1
   AST_ACCESS_CAS_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_fell && state == ST_ACT) |-> (cas_n ##1 !cas_n)); // R5
   AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && ras_n) |-> (we_n ##1 (!ras_n && !cas_n))); // R7
   AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      ras_fell |-> (hi_cnt >= SW'(T_RP))); // R6
   AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ras_fell |-> (since_fall >= SW'(T_RC))); // R6
   AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && ref_pend) |=> (state == ST_RCAS)); // R8
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R4
   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(!oe_n) && $past(we_n))); // R4
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> !req_ready); // R9

endmodule

// File: rtl/edo_macro_ctl.sv
module edo_macro_ctl #(
   parameter int ROW_W        = 9,
   parameter int COL_W        = 8,
   parameter int LANE_W       = 8,
   parameter int LANES        = 4,
   parameter int T_RAC        = 3,
   parameter int T_RP         = 2,
   parameter int T_RC         = 6,
   parameter int REF_INTERVAL = 1560,
   localparam int ADDR_W = ROW_W + COL_W,
   localparam int DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [ROW_W-1:0]  dram_row,
   output logic [COL_W-1:0]  dram_col,
   output logic [LANES-1:0]  dram_mask,
   output logic [DATA_W-1:0] dram_din,
   input  logic [DATA_W-1:0] dram_dout
);
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
      $error("edo_macro_ctl: address fields must be non-empty");
   end
   if (REF_INTERVAL <= T_RC + 2) begin : g_bad_ref
      $error("edo_macro_ctl: refresh interval shorter than a row cycle");
   end

   logic              ref_tick;
   logic              wr_active;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;

   edo_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ref_tick)
   );

   edo_seq #(
      .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W), .BE_W (LANES),
      .T_RAC (T_RAC), .T_RP (T_RP), .T_RC (T_RC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .ref_tick  (ref_tick),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .ras_n     (dram_ras_n),
      .cas_n     (dram_cas_n),
      .we_n      (dram_we_n),
      .oe_n      (dram_oe_n),
      .row       (dram_row),
      .col       (dram_col),
      .wr_active (wr_active),
      .wdata_q   (wdata_q),
      .be_q      (be_q),
      .dram_dout (dram_dout)
   );

   edo_mask_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
      .wr_active (wr_active),
      .be        (be_q),
      .wdata     (wdata_q),
      .mask      (dram_mask),
      .din       (dram_din)
   );

   AST_MASK_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (|dram_mask) |-> (!dram_we_n && !dram_ras_n && dram_oe_n)); // R3

endmodule

// File: tb/edo_macro_ctl_bench.sv
module edo_macro_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int T_RAC   = 3;
   localparam int T_RP    = 2;
   localparam int T_RC    = 6;
   localparam int REF_INT = 1560;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
   logic [8:0]  dram_row;
   logic [7:0]  dram_col;
   logic [3:0]  dram_mask;
   logic [31:0] dram_din;
   logic [31:0] dram_dout = 32'h0BAD_F00D;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int ref_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edo_macro_ctl u_edo_macro_ctl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_row(dram_row), .dram_col(dram_col),
      .dram_mask(dram_mask), .dram_din(dram_din), .dram_dout(dram_dout)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // array model, driven only through the macro pins
   logic [31:0] arr [int];
   always @(posedge clk) begin
      if (!dram_ras_n && !dram_cas_n && !dram_we_n) begin
         automatic int k = int'({dram_row, dram_col});
         automatic logic [31:0] w = arr.exists(k) ? arr[k] : 32'h0;
         for (int i = 0; i < 4; i++)
            if (dram_mask[i]) w[i*8 +: 8] = dram_din[i*8 +: 8];
         arr[k] = w;
      end
   end
   always @(negedge clk) begin
      automatic int k = int'({dram_row, dram_col});
      if (!dram_ras_n && !dram_cas_n && !dram_oe_n)
         dram_dout <= arr.exists(k) ? arr[k] : 32'h0;
      else
         dram_dout <= 32'h0BAD_F00D;
   end

   // expectations derived from the requirements
   logic [31:0] shadow [int];
   typedef struct { logic [31:0] data; int acc; } exp_t;
   exp_t sb [$];

   // monitor: responses, strobe order and spacing
   logic prev_ras = 1'b1, prev_cas = 1'b1;
   int   last_fall = -100, last_rise = -100;
   bit   cbr_next = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R3", "response without pending read", 32'h1, 32'h0);
            end else begin
               automatic exp_t e = sb.pop_front();
               chk(rsp_rdata == e.data, "R4", "read data", rsp_rdata, e.data);
               chk(cyc - e.acc == T_RAC, "R4", "read latency",
                   32'(cyc - e.acc), 32'(T_RAC));
            end
         end
         if (cbr_next) begin
            chk(!dram_ras_n && !dram_cas_n, "R7", "row strobe after column strobe",
                {30'h0, dram_ras_n, dram_cas_n}, 32'h0);
            cbr_next = 1'b0;
         end
         if (prev_cas && !dram_cas_n && dram_ras_n) begin
            ref_seen++;
            chk(dram_we_n, "R7", "write strobe high in refresh", 32'(dram_we_n), 32'h1);
            chk((cyc % REF_INT) >= 1 && (cyc % REF_INT) <= T_RC + 1, "R8",
                "refresh delay after due edge", 32'(cyc % REF_INT), 32'(T_RC + 1));
            cbr_next = 1'b1;
         end
         if (prev_ras && !dram_ras_n) begin
            chk(cyc - last_fall >= T_RC, "R6", "row cycle spacing",
                32'(cyc - last_fall), 32'(T_RC));
            chk(cyc - last_rise >= T_RP, "R6", "precharge time",
                32'(cyc - last_rise), 32'(T_RP));
            last_fall = cyc;
         end
         if (!prev_ras && dram_ras_n) last_rise = cyc;
         prev_ras = dram_ras_n;
         prev_cas = dram_cas_n;
      end
   end

   // driver: one request, with pin checks in the accepting and next cycle
   task automatic do_req(input bit wr, input logic [16:0] a, input logic [31:0] d,
                         input logic [3:0] be, output int acc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      acc = cyc;
      req_valid = 1'b0;
      chk(!dram_ras_n && dram_cas_n, "R5", "row strobe low, column high",
          {30'h0, dram_ras_n, dram_cas_n}, 32'h1);
      chk(dram_row == a[16:8] && dram_col == a[7:0], "R2", "row/column split",
          {15'h0, dram_row, dram_col}, {15'h0, a});
      chk(!req_ready, "R9", "ready while busy", 32'(req_ready), 32'h0);
      if (wr) begin
         automatic int k = int'(a);
         automatic logic [31:0] w = shadow.exists(k) ? shadow[k] : 32'h0;
         chk(!dram_we_n && dram_oe_n, "R3", "write strobes",
             {30'h0, dram_we_n, dram_oe_n}, 32'h1);
         chk(dram_mask == be, "R3", "byte masks", 32'(dram_mask), 32'(be));
         chk(dram_din == d, "R3", "write data", dram_din, d);
         for (int i = 0; i < 4; i++) if (be[i]) w[i*8 +: 8] = d[i*8 +: 8];
         shadow[k] = w;
      end else begin
         automatic int k = int'(a);
         automatic exp_t e;
         chk(dram_we_n && !dram_oe_n, "R4", "read strobes",
             {30'h0, dram_we_n, dram_oe_n}, 32'h2);
         e.data = shadow.exists(k) ? shadow[k] : 32'h0;
         e.acc  = acc;
         sb.push_back(e);
      end
      @(negedge clk);
      chk(!dram_cas_n, "R5", "column strobe one cycle later", 32'(dram_cas_n), 32'h0);
   endtask

   logic [16:0] pool [8];

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int a1, a2;
      pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h00100; pool[3] = 17'h000FF;
      pool[4] = 17'h1FF00; pool[5] = 17'h0A5C3; pool[6] = 17'h15A3C; pool[7] = 17'h00001;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "idle strobes",
             {28'h0, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 32'hF);
         chk(req_ready && !rsp_valid, "R1", "idle ready/response",
             {30'h0, req_ready, rsp_valid}, 32'h2);
         chk(dram_mask == 4'h0, "R3", "masks closed when idle", 32'(dram_mask), 32'h0);
      end

      // back-to-back reads of unwritten location
      do_req(1'b0, pool[0], 32'h0, 4'h0, a1);
      do_req(1'b0, pool[0], 32'h0, 4'h0, a2);
      chk(a2 - a1 == T_RC, "R6", "back-to-back acceptance spacing", 32'(a2 - a1), 32'(T_RC));

      // directed byte-mask cases
      do_req(1'b1, pool[5], 32'h1122_3344, 4'hF, a1);
      do_req(1'b1, pool[5], 32'hAABB_CCDD, 4'b0101, a1);
      do_req(1'b0, pool[5], 32'h0, 4'h0, a1);   // R3: expect 11BB33DD
      do_req(1'b1, pool[5], 32'hFFFF_FFFF, 4'b0000, a1);
      do_req(1'b0, pool[5], 32'h0, 4'h0, a1);   // R3: fully masked write leaves word
      do_req(1'b1, pool[1], 32'hCAFE_0001, 4'b1000, a1);
      do_req(1'b0, pool[1], 32'h0, 4'h0, a1);
      do_req(1'b1, pool[4], 32'h5555_AAAA, 4'hF, a1);
      do_req(1'b0, pool[3], 32'h0, 4'h0, a1);   // R2: neighbour keeps its own value
      do_req(1'b0, pool[4], 32'h0, 4'h0, a1);

      // mixed traffic spanning several refresh intervals (R7, R8)
      for (int n = 0; n < 700; n++) begin
         automatic int gap = $urandom_range(0, 3);
         do_req(1'($urandom_range(0, 1)), pool[$urandom_range(0, 7)], $urandom,
                4'($urandom_range(0, 15)), a1);
         repeat (gap) @(negedge clk);
      end

      repeat (20) @(negedge clk);
      chk(sb.size() == 0, "R4", "reads left unanswered", 32'(sb.size()), 32'h0);
      chk(ref_seen == (cyc - 8) / REF_INT, "R7", "refresh count",
          32'(ref_seen), 32'((cyc - 8) / REF_INT));
      chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes idle at end",
          {28'h0, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 32'hF);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule